// File: doc/BRIEF.md
# Addressing Mode Operand Fetch Unit

This unit sits between instruction decode and execution in an accumulator-based datapath. For each decoded instruction it takes a 4-bit mode code, an address field and a register-select field. It resolves the effective address and returns the operand. Some modes need no memory at all. Others make one read, or two reads in a chain, on a single-port synchronous memory whose data arrives one cycle after the read is issued.

The unit owns a small general register file, an index register and a base register. The datapath loads these through a plain load port. The autoincrement and autodecrement modes write the modified register back after its old value has been used as the address. The already-advanced program counter and the accumulator contents are inputs, and both are sampled when a request is accepted.

Requests enter on a valid/ready pair. `req_ready` is high only when the unit is idle, and a request transfers on a clock edge where `req_valid` and `req_ready` are both high. While the unit is busy, `req_ready` stays low, so an upstream stage holds its request until the unit can take it. Results leave as a one-cycle `done` pulse, with no back-pressure. `operand`, `eff_addr` and `illegal` are valid while `done` is high, and `operand` and `eff_addr` keep their values until the next result.

Top module: `opnd_resolver`

## Requirements
- R1: After reset, `req_ready` is 1, `done` and `mem_rd_en` are 0, and every general, index and base register holds zero.
- R2: Mode 0 (implied): the operand is `acc_in` as sampled at acceptance, `eff_addr` is 0, there is no memory read, and `done` rises one cycle after acceptance.
- R3: Mode 1 (immediate): the operand is the address field zero-extended to the data width, `eff_addr` is 0, there is no memory read, and `done` comes one cycle after acceptance.
- R4: Mode 4 (register): the operand is general register `req_rsel`, one of 2^RSEL_W registers, with no memory read and `done` after one cycle. Load target code 0 on `ld_tgt` writes general register `ld_sel`.
- R5: Mode 2 (direct): exactly one read is made at the address field, which is also `eff_addr`, and `done` comes 3 cycles after acceptance.
- R6: Mode 3 (indirect): the first read is at the address field. The low ADDR_W bits of its data give `eff_addr`, a second read there returns the operand, and `done` comes 5 cycles after acceptance.
- R7: Mode 5 (register indirect): the low ADDR_W bits of the selected register give `eff_addr`, one read there returns the operand, and `done` comes after 3 cycles.
- R8: Modes 6 and 7 (autoincrement, autodecrement) read like mode 5 at the register's old value. Afterwards the register holds the old value plus one or minus one, modulo 2^DATA_W.
- R9: Mode 8 (relative): `eff_addr` is `pc_in` plus the address field, taken as a two's-complement number, modulo 2^ADDR_W. One read is made, and `done` comes after 3 cycles.
- R10: Mode 9 (indexed) and mode 10 (base): `eff_addr` is the address field plus the index register or the base register, modulo 2^ADDR_W, with one read. Load target code 1 writes the index register and code 2 writes the base register.
- R11: Mode codes 11 to 15 finish one cycle after acceptance with `illegal` high together with `done`, operand 0, `eff_addr` 0 and no memory read.
- R12: From acceptance until the cycle after `done`, `req_ready` is 0 and `req_valid` has no effect. Each accepted request gives exactly one single-cycle `done` pulse.
- R13: `mem_rd_en` is never high in two consecutive cycles, and it is never high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle, request can transfer |
| req_mode | input | 4 | Mode code |
| req_addr | input | ADDR_W | Address field |
| req_rsel | input | RSEL_W | Register select |
| pc_in | input | ADDR_W | Program counter already past the instruction |
| acc_in | input | DATA_W | Accumulator contents |
| ld_en | input | 1 | Register load strobe |
| ld_tgt | input | 2 | Load target: 0 general, 1 index, 2 base |
| ld_sel | input | RSEL_W | General register to load |
| ld_data | input | DATA_W | Load value |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Read data, one cycle after the strobe |
| done | output | 1 | Result pulse |
| illegal | output | 1 | Unknown mode, valid with done |
| operand | output | DATA_W | Resolved operand |
| eff_addr | output | ADDR_W | Resolved effective address |

## Verification
The result is due 1, 3 or 5 cycles after the accepting edge, for no read, one read or two chained reads. The bench counts falling edges from that edge and demands `done` at exactly the expected count, not merely at some point. It samples `mem_rd_en` on every falling edge in between, so an extra or a missing read is counted. The autoincrement and autodecrement write-back lands 2 cycles after acceptance, so the bench reads the register back with a later register-mode request.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

  typedef enum logic [3:0] {
    M_IMPL = 4'd0,
    M_IMM  = 4'd1,
    M_DIR  = 4'd2,
    M_IND  = 4'd3,
    M_REG  = 4'd4,
    M_RIND = 4'd5,
    M_AINC = 4'd6,
    M_ADEC = 4'd7,
    M_REL  = 4'd8,
    M_IDX  = 4'd9,
    M_BASE = 4'd10
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RQ1,
    S_WT1,
    S_RQ2,
    S_WT2,
    S_FIN
  } state_e;

  localparam logic [1:0] LD_GPR  = 2'd0;
  localparam logic [1:0] LD_IDX  = 2'd1;
  localparam logic [1:0] LD_BASE = 2'd2;

endpackage

// File: rtl/opnd_regbank.sv
module opnd_regbank
  import opnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [1:0]        ld_tgt,
  input  logic [RSEL_W-1:0] ld_sel,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              wb_en,
  input  logic [RSEL_W-1:0] wb_sel,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [RSEL_W-1:0] rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] idx_q,
  output logic [DATA_W-1:0] base_q
);
  localparam int NREG = 1 << RSEL_W;

  logic [DATA_W-1:0] gpr_q [NREG];

  // Post-modify write-back wins over a same-cycle load of the same register.
  for (genvar g = 0; g < NREG; g++) begin : g_gpr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        gpr_q[g] <= '0;
      else if (wb_en && wb_sel == RSEL_W'(g))
        gpr_q[g] <= wb_data;
      else if (ld_en && ld_tgt == LD_GPR && ld_sel == RSEL_W'(g))
        gpr_q[g] <= ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      base_q <= '0;
    end else if (ld_en) begin
      if (ld_tgt == LD_IDX)  idx_q  <= ld_data;
      if (ld_tgt == LD_BASE) base_q <= ld_data;
    end
  end

  assign rd_data = gpr_q[rd_sel];

endmodule

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc
  import opnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-1:0] base,
  output logic              needs_mem,
  output logic              two_level,
  output logic              bad_mode,
  output logic              post_mod,
  output logic [DATA_W-1:0] post_val,
  output logic [ADDR_W-1:0] ea,
  output logic [DATA_W-1:0] local_val
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] reg_ea;
  assign reg_ea = reg_val[ADDR_W-1:0];

  always_comb begin
    needs_mem = 1'b1;
    two_level = 1'b0;
    bad_mode  = 1'b0;
    post_mod  = 1'b0;
    post_val  = reg_val;
    ea        = '0;
    local_val = '0;
    case (mode)
      M_IMPL: begin needs_mem = 1'b0; local_val = acc; end
      M_IMM:  begin needs_mem = 1'b0; local_val = {{PAD_W{1'b0}}, addr}; end
      M_REG:  begin needs_mem = 1'b0; local_val = reg_val; end
      M_DIR:  ea = addr;
      M_IND:  begin ea = addr; two_level = 1'b1; end
      M_RIND: ea = reg_ea;
      M_AINC: begin ea = reg_ea; post_mod = 1'b1; post_val = reg_val + 1'b1; end
      M_ADEC: begin ea = reg_ea; post_mod = 1'b1; post_val = reg_val - 1'b1; end
      M_REL:  ea = addr + pc;
      M_IDX:  ea = addr + idx[ADDR_W-1:0];
      M_BASE: ea = addr + base[ADDR_W-1:0];
      default: begin needs_mem = 1'b0; bad_mode = 1'b1; end
    endcase
  end

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
  import opnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int RSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              needs_mem,
  input  logic              two_level,
  input  logic              bad_mode,
  input  logic              post_mod,
  input  logic [DATA_W-1:0] post_val,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] local_val,
  input  logic [RSEL_W-1:0] rsel,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              idle,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wb_en,
  output logic [RSEL_W-1:0] wb_sel,
  output logic [DATA_W-1:0] wb_data,
  output logic              done,
  output logic              illegal,
  output logic [DATA_W-1:0] operand,
  output logic [ADDR_W-1:0] eff_addr
);
  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] ea_q;
  logic [DATA_W-1:0] op_q;
  logic [DATA_W-1:0] post_q;
  logic [RSEL_W-1:0] rsel_q;
  logic              two_q;
  logic              pm_q;
  logic              ill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      ea_q    <= '0;
      op_q    <= '0;
      post_q  <= '0;
      rsel_q  <= '0;
      two_q   <= 1'b0;
      pm_q    <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          rsel_q <= rsel;
          pm_q   <= post_mod;
          post_q <= post_val;
          two_q  <= two_level;
          ill_q  <= bad_mode;
          if (needs_mem) begin
            addr_q  <= ea;
            state_q <= S_RQ1;
          end else begin
            op_q    <= local_val;
            ea_q    <= '0;
            state_q <= S_FIN;
          end
        end
        S_RQ1: state_q <= S_WT1;
        S_WT1: begin
          if (two_q) begin
            addr_q  <= mem_rdata[ADDR_W-1:0];
            state_q <= S_RQ2;
          end else begin
            op_q    <= mem_rdata;
            ea_q    <= addr_q;
            state_q <= S_FIN;
          end
        end
        S_RQ2: state_q <= S_WT2;
        S_WT2: begin
          op_q    <= mem_rdata;
          ea_q    <= addr_q;
          state_q <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == S_IDLE);
  assign mem_rd_en = (state_q == S_RQ1) || (state_q == S_RQ2);
  assign mem_addr  = addr_q;
  // Write-back lands on the edge that captures the first read: after use.
  assign wb_en     = (state_q == S_WT1) && pm_q;
  assign wb_sel    = rsel_q;
  assign wb_data   = post_q;
  assign done      = (state_q == S_FIN);
  assign illegal   = done && ill_q;
  assign operand   = op_q;
  assign eff_addr  = ea_q;

endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int RSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [RSEL_W-1:0] req_rsel,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              ld_en,
  input  logic [1:0]        ld_tgt,
  input  logic [RSEL_W-1:0] ld_sel,
  input  logic [DATA_W-1:0] ld_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              illegal,
  output logic [DATA_W-1:0] operand,
  output logic [ADDR_W-1:0] eff_addr
);
  logic              accept;
  logic              wb_en;
  logic [RSEL_W-1:0] wb_sel;
  logic [DATA_W-1:0] wb_data;
  logic [DATA_W-1:0] reg_val, idx_val, base_val;
  logic              needs_mem, two_level, bad_mode, post_mod;
  logic [DATA_W-1:0] post_val, local_val;
  logic [ADDR_W-1:0] ea;

  assign accept = req_valid && req_ready;

  opnd_regbank #(.DATA_W(DATA_W), .RSEL_W(RSEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_tgt  (ld_tgt),
    .ld_sel  (ld_sel),
    .ld_data (ld_data),
    .wb_en   (wb_en),
    .wb_sel  (wb_sel),
    .wb_data (wb_data),
    .rd_sel  (req_rsel),
    .rd_data (reg_val),
    .idx_q   (idx_val),
    .base_q  (base_val)
  );

  opnd_ea_calc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ea (
    .mode      (req_mode),
    .addr      (req_addr),
    .pc        (pc_in),
    .acc       (acc_in),
    .reg_val   (reg_val),
    .idx       (idx_val),
    .base      (base_val),
    .needs_mem (needs_mem),
    .two_level (two_level),
    .bad_mode  (bad_mode),
    .post_mod  (post_mod),
    .post_val  (post_val),
    .ea        (ea),
    .local_val (local_val)
  );

  opnd_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RSEL_W(RSEL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .needs_mem (needs_mem),
    .two_level (two_level),
    .bad_mode  (bad_mode),
    .post_mod  (post_mod),
    .post_val  (post_val),
    .ea        (ea),
    .local_val (local_val),
    .rsel      (req_rsel),
    .mem_rdata (mem_rdata),
    .idle      (req_ready),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .wb_en     (wb_en),
    .wb_sel    (wb_sel),
    .wb_data   (wb_data),
    .done      (done),
    .illegal   (illegal),
    .operand   (operand),
    .eff_addr  (eff_addr)
  );

endmodule

// File: rtl/opnd_resolver_chk.sv
module opnd_resolver_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_mode,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] pc_in,
  input logic              mem_rd_en,
  input logic              done,
  input logic              illegal,
  input logic [ADDR_W-1:0] eff_addr
);
  logic [3:0]        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] pc_q;
  logic [1:0]        rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      addr_q <= '0;
      pc_q   <= '0;
      rd_cnt <= '0;
    end else if (req_valid && req_ready) begin
      mode_q <= req_mode;
      addr_q <= req_addr;
      pc_q   <= pc_in;
      rd_cnt <= '0;
    end else if (mem_rd_en && rd_cnt != 2'd3) begin
      rd_cnt <= rd_cnt + 2'd1;
    end
  end

  AST_NOMEM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q == 4'd0 || mode_q == 4'd1 || mode_q == 4'd4) |-> rd_cnt == 2'd0); // R2
  AST_DIRECT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 4'd2 |-> rd_cnt == 2'd1 && eff_addr == addr_q); // R5
  AST_INDIRECT_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 4'd3 |-> rd_cnt == 2'd2); // R6
  AST_RELATIVE_EA: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 4'd8 |-> eff_addr == ADDR_W'(addr_q + pc_q)); // R9
  AST_ILLEGAL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q > 4'd10 |-> illegal && rd_cnt == 2'd0); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready); // R12
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R13
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready); // R13

endmodule

bind opnd_resolver opnd_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mode  (req_mode),
  .req_addr  (req_addr),
  .pc_in     (pc_in),
  .mem_rd_en (mem_rd_en),
  .done      (done),
  .illegal   (illegal),
  .eff_addr  (eff_addr)
);

// File: tb/opnd_resolver_tb.sv
module opnd_resolver_tb;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [3:0]    req_mode = '0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_rsel = '0;
  logic [AW-1:0] pc_in = '0;
  logic [DW-1:0] acc_in = '0;
  logic          ld_en = 1'b0;
  logic [1:0]    ld_tgt = '0;
  logic [SW-1:0] ld_sel = '0;
  logic [DW-1:0] ld_data = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          done, illegal;
  logic [DW-1:0] operand;
  logic [AW-1:0] eff_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  opnd_resolver #(.DATA_W(DW), .ADDR_W(AW), .RSEL_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_addr(req_addr), .req_rsel(req_rsel),
    .pc_in(pc_in), .acc_in(acc_in), .ld_en(ld_en), .ld_tgt(ld_tgt),
    .ld_sel(ld_sel), .ld_data(ld_data), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
    .illegal(illegal), .operand(operand), .eff_addr(eff_addr)
  );

  // Behavioural memory: word a holds 0xA000 + ((5a + 3) mod 1024).
  logic [DW-1:0] mem [1024];
  initial for (int i = 0; i < 1024; i++) mem[i] = 16'hA000 + DW'((i * 5 + 3) % 1024);
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  typedef struct packed {
    logic [3:0]    mode;
    logic [AW-1:0] addr;
    logic [SW-1:0] rsel;
    logic [AW-1:0] pc;
    logic [DW-1:0] acc;
    logic [DW-1:0] op;
    logic [AW-1:0] ea;
    logic [2:0]    lat;
    logic [1:0]    reads;
    logic          ill;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  10'd5,   2'd0, 10'd0,   16'h1234, 16'h1234, 10'd0,   3'd1, 2'd0, 1'b0}, // R2
    '{4'd1,  10'h3AB, 2'd0, 10'd0,   16'h0000, 16'h03AB, 10'd0,   3'd1, 2'd0, 1'b0}, // R3
    '{4'd2,  10'd100, 2'd0, 10'd0,   16'h0000, 16'hA1F7, 10'd100, 3'd3, 2'd1, 1'b0}, // R5
    '{4'd3,  10'd100, 2'd0, 10'd0,   16'h0000, 16'hA1D6, 10'd503, 3'd5, 2'd2, 1'b0}, // R6
    '{4'd4,  10'd0,   2'd3, 10'd0,   16'h0000, 16'h8001, 10'd0,   3'd1, 2'd0, 1'b0}, // R4
    '{4'd5,  10'd0,   2'd1, 10'd0,   16'h0000, 16'hA203, 10'd512, 3'd3, 2'd1, 1'b0}, // R7
    '{4'd8,  10'd24,  2'd0, 10'd826, 16'h0000, 16'hA09D, 10'd850, 3'd3, 2'd1, 1'b0}, // R9
    '{4'd8,  10'h3F6, 2'd0, 10'd5,   16'h0000, 16'hA3EA, 10'd1019,3'd3, 2'd1, 1'b0}, // R9
    '{4'd9,  10'h010, 2'd0, 10'd0,   16'h0000, 16'hA193, 10'd80,  3'd3, 2'd1, 1'b0}, // R10
    '{4'd10, 10'h123, 2'd0, 10'd0,   16'h0000, 16'hA0B2, 10'd35,  3'd3, 2'd1, 1'b0}, // R10
    '{4'd11, 10'd7,   2'd0, 10'd0,   16'h5555, 16'h0000, 10'd0,   3'd1, 2'd0, 1'b1}  // R11
  };
  localparam string TAGS [NV] = '{"R2", "R3", "R5", "R6", "R4", "R7", "R9", "R9",
                                  "R10", "R10", "R11"};

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] tgt, input logic [SW-1:0] sel,
                      input logic [DW-1:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_tgt = tgt; ld_sel = sel; ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input vec_t v, input string tag);
    int seen_at = 0;
    int reads = 0;
    logic [DW-1:0] got_op = '0;
    logic [AW-1:0] got_ea = '0;
    logic got_ill = 1'b0;
    @(negedge clk);
    chk(tag, "ready before request", 32'(req_ready), 32'd1);
    req_mode = v.mode; req_addr = v.addr; req_rsel = v.rsel;
    pc_in = v.pc; acc_in = v.acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      if (mem_rd_en) reads++;
      if (done) begin
        if (seen_at == 0) begin
          seen_at = k; got_op = operand; got_ea = eff_addr; got_ill = illegal;
        end else begin
          seen_at = 99;
        end
      end
      @(negedge clk);
    end
    chk(tag, "done cycle", 32'(seen_at), 32'(v.lat));
    chk(tag, "operand", 32'(got_op), 32'(v.op));
    chk(tag, "eff_addr", 32'(got_ea), 32'(v.ea));
    chk(tag, "illegal", 32'(got_ill), 32'(v.ill));
    chk(tag, "reads", 32'(reads), 32'(v.reads));
  endtask

  function automatic vec_t mk(input logic [3:0] m, input logic [AW-1:0] a,
                              input logic [SW-1:0] s, input logic [DW-1:0] op,
                              input logic [AW-1:0] ea, input logic [2:0] lat,
                              input logic [1:0] rd, input logic il);
    return '{m, a, s, 10'd0, 16'h0000, op, ea, lat, rd, il};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset and zeroed registers
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "mem_rd_en", 32'(mem_rd_en), 32'd0);
    run(mk(4'd4, 10'd0, 2'd1, 16'h0000, 10'd0, 3'd1, 2'd0, 1'b0), "R1");
    run(mk(4'd9, 10'd7, 2'd0, 16'hA026, 10'd7, 3'd3, 2'd1, 1'b0), "R1");

    load(2'd0, 2'd0, 16'h0010);
    load(2'd0, 2'd1, 16'h0200);
    load(2'd0, 2'd2, 16'h03FF);
    load(2'd0, 2'd3, 16'h8001);
    load(2'd1, 2'd0, 16'h0040);
    load(2'd2, 2'd0, 16'h0300);

    for (int i = 0; i < NV; i++) run(VECS[i], TAGS[i]);

    // R4: every one of the 2^k general registers is selectable
    run(mk(4'd4, 10'd0, 2'd0, 16'h0010, 10'd0, 3'd1, 2'd0, 1'b0), "R4");
    run(mk(4'd4, 10'd0, 2'd1, 16'h0200, 10'd0, 3'd1, 2'd0, 1'b0), "R4");
    run(mk(4'd4, 10'd0, 2'd2, 16'h03FF, 10'd0, 3'd1, 2'd0, 1'b0), "R4");

    // R8: autoincrement then autodecrement on register 0, post-use update
    run(mk(4'd6, 10'd0, 2'd0, 16'hA053, 10'd16, 3'd3, 2'd1, 1'b0), "R8");
    run(mk(4'd4, 10'd0, 2'd0, 16'h0011, 10'd0, 3'd1, 2'd0, 1'b0), "R8");
    run(mk(4'd7, 10'd0, 2'd0, 16'hA058, 10'd17, 3'd3, 2'd1, 1'b0), "R8");
    run(mk(4'd4, 10'd0, 2'd0, 16'h0010, 10'd0, 3'd1, 2'd0, 1'b0), "R8");
    // R8: increment wraps the full data width
    load(2'd0, 2'd3, 16'hFFFF);
    run(mk(4'd6, 10'd0, 2'd3, 16'hA3FE, 10'd1023, 3'd3, 2'd1, 1'b0), "R8");
    run(mk(4'd4, 10'd0, 2'd3, 16'h0000, 10'd0, 3'd1, 2'd0, 1'b0), "R8");
    // R8: decrement wraps below zero
    run(mk(4'd7, 10'd0, 2'd3, 16'hA003, 10'd0, 3'd3, 2'd1, 1'b0), "R8");
    run(mk(4'd4, 10'd0, 2'd3, 16'hFFFF, 10'd0, 3'd1, 2'd0, 1'b0), "R8");

    // R11: highest unused code
    run(mk(4'd15, 10'd100, 2'd0, 16'h0000, 10'd0, 3'd1, 2'd0, 1'b1), "R11");

    // R12: a request held while busy is ignored until the unit is idle
    begin
      int dones = 0;
      logic [DW-1:0] got = '0;
      @(negedge clk);
      req_mode = 4'd2; req_addr = 10'd100; req_valid = 1'b1;
      @(negedge clk);
      req_mode = 4'd0; acc_in = 16'hBEEF;
      for (int k = 1; k <= 3; k++) begin
        if (k < 3) chk("R12", "ready while busy", 32'(req_ready), 32'd0);
        if (done) begin dones++; got = operand; end
        if (k == 3) req_valid = 1'b0;
        @(negedge clk);
      end
      for (int k = 0; k < 4; k++) begin
        if (done) dones++;
        @(negedge clk);
      end
      chk("R12", "done pulses", 32'(dones), 32'd1);
      chk("R12", "operand of first request", 32'(got), 32'hA1F7);
    end

    // R13: chained reads are separate single-cycle strobes
    begin
      int prev = 0;
      int bad = 0;
      @(negedge clk);
      req_mode = 4'd3; req_addr = 10'd100; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 7; k++) begin
        if (mem_rd_en && prev != 0) bad++;
        if (mem_rd_en && req_ready) bad++;
        prev = int'(mem_rd_en);
        @(negedge clk);
      end
      chk("R13", "read strobe shape", 32'(bad), 32'd0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule